// File: doc/BRIEF.md
# Two-Stage Memory Attribute Combiner

This block merges the memory attributes that come out of two address translation stages into one effective attribute set. The first stage belongs to the guest operating system. The second stage belongs to the hypervisor. Each stage supplies three things: a memory type (Device or Normal), a cacheability class, and read and write permission enables. The block combines them so that the more restrictive value of each field wins.

Three hypervisor controls can change that default. A force-non-cacheable control marks the first-stage cacheability as non-cacheable. A force-default control makes the first stage look like Normal write-back memory. A second-stage-wins control takes type and cacheability straight from the second stage. Permissions are always the intersection of the two stages. The combined result is held in one output register stage, so it reaches the ports one clock after the inputs are sampled.

Top module: `memattr_combine`

## Requirements
- R1: While the active-low reset is asserted, the outputs are type Device, cacheability non-cacheable and all permission bits 0.
- R2: The outputs reflect the inputs sampled at the previous rising clock edge. They do not change between edges.
- R3: Type encoding is 0 = Device and 1 = Normal. Without the second-stage-wins control, the output type is Device whenever either stage (after any first-stage forcing) is Device.
- R4: Cacheability encoding is 0 = non-cacheable, 1 = write-through, 2 = write-back. Code 3 is read as non-cacheable. Without the second-stage-wins control, the output is the more restrictive of the two stages, in the order non-cacheable, then write-through, then write-back (most restrictive first).
- R5: Permission bit 0 is read and bit 1 is write. Each output permission bit is the AND of the two stages' bits, including when the second-stage-wins control is set.
- R6: With the force-non-cacheable control set, the first-stage cacheability is replaced by non-cacheable before combining. The first-stage type is left as it is.
- R7: With only the force-default control set, the first stage is replaced by Normal write-back before combining.
- R8: With both force controls set, force-non-cacheable takes priority and force-default has no effect.
- R9: With the second-stage-wins control set, the output type and cacheability come from the second stage alone.
- R10: Whenever the output type is Device, the output cacheability is non-cacheable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s1_type | input | 1 | First-stage type (0 Device, 1 Normal) |
| s1_cache | input | 2 | First-stage cacheability code |
| s1_perm | input | PERM_W | First-stage permissions (bit0 read, bit1 write) |
| s2_type | input | 1 | Second-stage type |
| s2_cache | input | 2 | Second-stage cacheability code |
| s2_perm | input | PERM_W | Second-stage permissions |
| ctl_force_nc | input | 1 | Treat the first stage as non-cacheable |
| ctl_force_dflt | input | 1 | Treat the first stage as Normal write-back |
| ctl_s2_wins | input | 1 | Take type and cacheability from the second stage |
| eff_type | output | 1 | Effective type |
| eff_cache | output | 2 | Effective cacheability |
| eff_perm | output | PERM_W | Effective permissions |

## Verification
On every cycle, the assertions check these relations between inputs and outputs:
- a Device output always carries non-cacheable;
- a Device second stage always yields a Device result;
- the second-stage-wins path copies the second-stage type;
- permissions equal the AND of the previous cycle's inputs;
- the merged cacheability never exceeds the second stage's class.

Some behaviour can only be shown by the bench's scenarios:
- the priority between the two force controls;
- the exact class chosen by the most-restrictive merge;
- reading code 3 as non-cacheable;
- the reset values and the one-cycle latency.

// File: rtl/memattr_pkg.sv
package memattr_pkg;

  typedef enum logic {
    MT_DEV  = 1'b0,
    MT_NORM = 1'b1
  } mtype_e;

  typedef enum logic [1:0] {
    CA_NC  = 2'd0,
    CA_WT  = 2'd1,
    CA_WB  = 2'd2,
    CA_RSV = 2'd3
  } cache_e;

  localparam int unsigned CACHE_W = 2;

  // The reserved code is read as the most restrictive class.
  function automatic cache_e cache_norm(input logic [CACHE_W-1:0] c);
    cache_e r;
    if (c == CA_RSV) r = CA_NC;
    else             r = cache_e'(c);
    return r;
  endfunction

  // Smaller code means more restrictive.
  function automatic cache_e cache_min(input cache_e a, input cache_e b);
    cache_e r;
    if (a < b) r = a;
    else       r = b;
    return r;
  endfunction

endpackage

// File: rtl/memattr_s1_adjust.sv
module memattr_s1_adjust
  import memattr_pkg::*;
(
  input  mtype_e               raw_type,
  input  logic [CACHE_W-1:0]   raw_cache,
  input  logic                 force_nc,
  input  logic                 force_dflt,
  output mtype_e               adj_type,
  output cache_e               adj_cache
);

  always_comb begin
    adj_type  = raw_type;
    adj_cache = cache_norm(raw_cache);
    if (force_nc) begin
      adj_cache = CA_NC;
    end else if (force_dflt) begin
      adj_type  = MT_NORM;
      adj_cache = CA_WB;
    end
  end

endmodule

// File: rtl/memattr_merge.sv
module memattr_merge
  import memattr_pkg::*;
#(
  parameter int unsigned PERM_W = 2
) (
  input  mtype_e              a_type,
  input  cache_e              a_cache,
  input  logic [PERM_W-1:0]   a_perm,
  input  mtype_e              b_type,
  input  logic [CACHE_W-1:0]  b_cache,
  input  logic [PERM_W-1:0]   b_perm,
  output mtype_e              m_type,
  output cache_e              m_cache,
  output logic [PERM_W-1:0]   m_perm
);

  cache_e b_cache_n;

  always_comb begin
    b_cache_n = cache_norm(b_cache);
    if (a_type == MT_DEV || b_type == MT_DEV) m_type = MT_DEV;
    else                                      m_type = MT_NORM;
    m_cache = cache_min(a_cache, b_cache_n);
  end

  for (genvar gi = 0; gi < PERM_W; gi++) begin : g_perm
    assign m_perm[gi] = a_perm[gi] & b_perm[gi];
  end

endmodule

// File: rtl/memattr_select.sv
module memattr_select
  import memattr_pkg::*;
(
  input  logic                s2_wins,
  input  mtype_e              m_type,
  input  cache_e              m_cache,
  input  mtype_e              s2_type,
  input  logic [CACHE_W-1:0]  s2_cache,
  output mtype_e              f_type,
  output cache_e              f_cache
);

  always_comb begin
    if (s2_wins) begin
      f_type  = s2_type;
      f_cache = cache_norm(s2_cache);
    end else begin
      f_type  = m_type;
      f_cache = m_cache;
    end
    if (f_type == MT_DEV) f_cache = CA_NC;
  end

endmodule

// File: rtl/memattr_combine.sv
module memattr_combine
  import memattr_pkg::*;
#(
  parameter int unsigned PERM_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s1_type,
  input  logic [1:0]         s1_cache,
  input  logic [PERM_W-1:0]  s1_perm,
  input  logic               s2_type,
  input  logic [1:0]         s2_cache,
  input  logic [PERM_W-1:0]  s2_perm,
  input  logic               ctl_force_nc,
  input  logic               ctl_force_dflt,
  input  logic               ctl_s2_wins,
  output logic               eff_type,
  output logic [1:0]         eff_cache,
  output logic [PERM_W-1:0]  eff_perm
);

  mtype_e             s1a_type, mg_type, sel_type;
  cache_e             s1a_cache, mg_cache, sel_cache;
  logic [PERM_W-1:0]  mg_perm;

  mtype_e             type_q, type_d;
  cache_e             cache_q, cache_d;
  logic [PERM_W-1:0]  perm_q, perm_d;

  memattr_s1_adjust u_adj (
    .raw_type   (mtype_e'(s1_type)),
    .raw_cache  (s1_cache),
    .force_nc   (ctl_force_nc),
    .force_dflt (ctl_force_dflt),
    .adj_type   (s1a_type),
    .adj_cache  (s1a_cache)
  );

  memattr_merge #(.PERM_W(PERM_W)) u_mrg (
    .a_type  (s1a_type),
    .a_cache (s1a_cache),
    .a_perm  (s1_perm),
    .b_type  (mtype_e'(s2_type)),
    .b_cache (s2_cache),
    .b_perm  (s2_perm),
    .m_type  (mg_type),
    .m_cache (mg_cache),
    .m_perm  (mg_perm)
  );

  memattr_select u_sel (
    .s2_wins  (ctl_s2_wins),
    .m_type   (mg_type),
    .m_cache  (mg_cache),
    .s2_type  (mtype_e'(s2_type)),
    .s2_cache (s2_cache),
    .f_type   (sel_type),
    .f_cache  (sel_cache)
  );

  // Next-state process
  always_comb begin
    type_d  = sel_type;
    cache_d = sel_cache;
    perm_d  = mg_perm;
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q  <= MT_DEV;
      cache_q <= CA_NC;
      perm_q  <= '0;
    end else begin
      type_q  <= type_d;
      cache_q <= cache_d;
      perm_q  <= perm_d;
    end
  end

  assign eff_type  = type_q;
  assign eff_cache = cache_q;
  assign eff_perm  = perm_q;

endmodule

// File: rtl/memattr_chk.sv
module memattr_chk #(
  parameter int unsigned PERM_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               s1_type,
  input logic [1:0]         s1_cache,
  input logic [PERM_W-1:0]  s1_perm,
  input logic               s2_type,
  input logic [1:0]         s2_cache,
  input logic [PERM_W-1:0]  s2_perm,
  input logic               ctl_force_nc,
  input logic               ctl_force_dflt,
  input logic               ctl_s2_wins,
  input logic               eff_type,
  input logic [1:0]         eff_cache,
  input logic [PERM_W-1:0]  eff_perm
);

  AST_DEVICE_IS_NC: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_type == 1'b0) |-> (eff_cache == 2'd0)); // R10

  AST_S2_DEVICE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_s2_wins && s2_type == 1'b0) |=> (eff_type == 1'b0)); // R3

  AST_S2_TYPE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_s2_wins |=> (eff_type == $past(s2_type))); // R9

  AST_PERM_INTERSECT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (eff_perm == ($past(s1_perm) & $past(s2_perm)))); // R5

  AST_CACHE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_s2_wins && s2_cache != 2'd3) |=> (eff_cache <= $past(s2_cache))); // R4

  AST_CACHE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    eff_cache != 2'd3); // R4

endmodule

bind memattr_combine memattr_chk #(.PERM_W(PERM_W)) u_chk (.*);

// File: tb/sim_memattr_combine.sv
module sim_memattr_combine;

  logic       clk;
  logic       rst_n;
  logic       s1_type, s2_type;
  logic [1:0] s1_cache, s2_cache;
  logic [1:0] s1_perm, s2_perm;
  logic       ctl_force_nc, ctl_force_dflt, ctl_s2_wins;
  logic       eff_type;
  logic [1:0] eff_cache;
  logic [1:0] eff_perm;

  int n_chk;
  int n_fail;

  memattr_combine #(.PERM_W(2)) u0 (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Vector layout: {force_nc, force_dflt, s2_wins,
  //   s1_type, s1_cache, s1_perm, s2_type, s2_cache, s2_perm,
  //   exp_type, exp_cache, exp_perm}
  // Type: 0 Device, 1 Normal. Cache: 0 NC, 1 WT, 2 WB, 3 reserved.
  localparam int NV = 15;
  localparam logic [22:0] VEC [NV] = '{
    {3'b000, 1'b1,2'd2,2'b11, 1'b1,2'd1,2'b01, 1'b1,2'd1,2'b01}, // R4
    {3'b000, 1'b1,2'd1,2'b11, 1'b1,2'd2,2'b11, 1'b1,2'd1,2'b11}, // R4
    {3'b000, 1'b0,2'd2,2'b11, 1'b1,2'd2,2'b11, 1'b0,2'd0,2'b11}, // R3
    {3'b000, 1'b1,2'd2,2'b11, 1'b0,2'd2,2'b10, 1'b0,2'd0,2'b10}, // R3
    {3'b000, 1'b1,2'd3,2'b11, 1'b1,2'd2,2'b11, 1'b1,2'd0,2'b11}, // R4
    {3'b000, 1'b1,2'd2,2'b10, 1'b1,2'd2,2'b01, 1'b1,2'd2,2'b00}, // R5
    {3'b100, 1'b1,2'd2,2'b11, 1'b1,2'd2,2'b11, 1'b1,2'd0,2'b11}, // R6
    {3'b010, 1'b0,2'd0,2'b11, 1'b1,2'd2,2'b11, 1'b1,2'd2,2'b11}, // R7
    {3'b010, 1'b0,2'd0,2'b11, 1'b1,2'd1,2'b11, 1'b1,2'd1,2'b11}, // R7
    {3'b110, 1'b0,2'd0,2'b11, 1'b1,2'd2,2'b11, 1'b0,2'd0,2'b11}, // R8
    {3'b001, 1'b0,2'd0,2'b11, 1'b1,2'd2,2'b11, 1'b1,2'd2,2'b11}, // R9
    {3'b101, 1'b1,2'd0,2'b11, 1'b1,2'd1,2'b11, 1'b1,2'd1,2'b11}, // R9
    {3'b001, 1'b1,2'd2,2'b01, 1'b1,2'd2,2'b11, 1'b1,2'd2,2'b01}, // R5
    {3'b001, 1'b1,2'd2,2'b11, 1'b0,2'd2,2'b11, 1'b0,2'd0,2'b11}, // R10
    {3'b000, 1'b1,2'd0,2'b11, 1'b1,2'd2,2'b11, 1'b1,2'd0,2'b11}  // R4
  };
  localparam int VREQ [NV] = '{4, 4, 3, 3, 4, 5, 6, 7, 7, 8, 9, 9, 5, 10, 4};

  task automatic drive(input logic [17:0] s);
    {ctl_force_nc, ctl_force_dflt, ctl_s2_wins,
     s1_type, s1_cache, s1_perm, s2_type, s2_cache, s2_perm} = s;
  endtask

  task automatic check(input string req, input logic [4:0] exp);
    n_chk++;
    if ({eff_type, eff_cache, eff_perm} !== exp) begin
      n_fail++;
      $display("FAIL %s: got type=%0d cache=%0d perm=%b, expected type=%0d cache=%0d perm=%b",
               req, eff_type, eff_cache, eff_perm, exp[4], exp[3:2], exp[1:0]);
    end
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    drive(18'h3ffff);
    repeat (3) @(negedge clk);
    check("R1", {1'b0, 2'd0, 2'b00});          // R1 reset values
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][22:5]);
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VREQ[i], i), VEC[i][4:0]);
    end

    // R2: output holds until the next edge, then follows
    drive({3'b000, 1'b1,2'd2,2'b11, 1'b1,2'd2,2'b11});
    @(negedge clk);
    drive({3'b000, 1'b1,2'd1,2'b01, 1'b1,2'd2,2'b11});
    #1;
    check("R2 hold", {1'b1, 2'd2, 2'b11});
    @(negedge clk);
    check("R2 update", {1'b1, 2'd1, 2'b01});

    // R8 with Normal first stage: NC still wins over default
    drive({3'b110, 1'b1,2'd2,2'b11, 1'b1,2'd2,2'b11});
    @(negedge clk);
    check("R8 normal", {1'b1, 2'd0, 2'b11});

    // R1: reset asserted mid-run clears the outputs
    #1 rst_n = 1'b0;
    #1;
    check("R1 async", {1'b0, 2'd0, 2'b00});
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after reset", {1'b1, 2'd0, 2'b11});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #20000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule